// File: doc/BRIEF.md
# Multi-Source Power Control Arbiter

This block gathers power requests from seven initiators and drives one system power-enable output. The initiators are a front-panel button, an internal watchdog, a command interface, AC-return state retention, the chipset sleep signal, a CPU thermal-trip input and a wake-on-LAN input. Every request passes through a filter for its source. The filter admits only the actions that source may take. It also drops any action that would not change the current power state. Among the requests that survive, a fixed priority picks one winner per clock.

A power-cycle request drops the enable. It holds the enable low for a programmable number of clock ticks, then raises it again. No request is taken during that window. Thermal trip outranks every other source and blocks all power-on actions while it is asserted. The block reports the power state, a registered code for the source of the last transition, and a one-cycle pulse whenever the enable changes.

All inputs are sampled on the rising clock edge. Every output is a register that updates on the edge that takes the winning request.

Top module: `pwr_ctrl_arbiter`

## Requirements
- R1: During and after synchronous reset, `pwr_en` is 0, `pwr_state` is 00, `last_cause` is 0 and `change_pulse` is 0.
- R2: A one-cycle `btn_press` toggles power. It turns power on from state off and turns it off from state on.
- R3: `wdt_action` uses the code 00 none, 01 on, 10 off, 11 cycle. The watchdog may only turn power off or start a power cycle, so code 01 never turns power on.
- R4: `cmd_action` uses the same code as `wdt_action`, and all three actions (on, off, cycle) are honoured.
- R5: `ac_return` turns power on from state off only when `restore_en` is 1. It never turns power off.
- R6: The chipset request follows the level of `chipset_sleep`. A rise (entering sleep) requests off, a fall requests on, and a steady level requests nothing. The edge detector resets as if sleep were asserted.
- R7: While `thermal_trip` is 1, power is off by the following clock and every power-on action from any source is dropped.
- R8: A one-cycle `wake_lan` only turns power on and never turns it off.
- R9: A cycle request in state on enters state cycling. `pwr_en` is then low for max(`off_ticks`,1) clocks, with `off_ticks` captured at the start, and then returns high. Every request during the window is dropped. If `thermal_trip` is 1 when the window ends, the state goes to off instead. A cycle request in state off is dropped.
- R10: Only requests that change the state compete. Among simultaneous competing requests the priority, highest first, is thermal, watchdog, command, button, chipset, wake-on-LAN, retention.
- R11: `last_cause` is updated on each transition. The codes are 1 button, 2 watchdog, 3 command, 4 retention, 5 chipset, 6 thermal, 7 wake-on-LAN. The power-on at the end of a cycle keeps the code of the cycle's source.
- R12: `change_pulse` is high for exactly the one clock in which `pwr_en` shows a new value.
- R13: `pwr_state` reads 00 off, 01 on, 10 cycling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_press | input | 1 | One-cycle front-panel press (toggle) |
| wdt_action | input | 2 | Watchdog action code |
| cmd_action | input | 2 | Command interface action code |
| ac_return | input | 1 | One-cycle AC power return indication |
| restore_en | input | 1 | Retention policy: restore power on AC return |
| chipset_sleep | input | 1 | Chipset deep-sleep level (1 = asleep) |
| thermal_trip | input | 1 | CPU thermal-trip level |
| wake_lan | input | 1 | One-cycle wake-on-LAN event |
| off_ticks | input | CNT_W | Power-cycle off duration in clocks |
| pwr_en | output | 1 | System power enable |
| pwr_state | output | 2 | Current power state |
| last_cause | output | 3 | Source of the last transition |
| change_pulse | output | 1 | One-cycle pulse when pwr_en changes |

## Verification
The bench builds the arbiter with CNT_W = 6, so it can also drive the largest off window of 63 ticks and count it clock by clock in a short run. It also covers the zero-tick case, which must behave like a one-tick window. With this narrow counter, every window-length corner is reachable in a few hundred clocks. The default width of 16 uses the same counter logic.

// File: rtl/pwr_arb_pkg.sv
`timescale 1ns/1ps
package pwr_arb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_ON    = 2'b01,
    ACT_OFF   = 2'b10,
    ACT_CYCLE = 2'b11
  } pwr_act_e;

  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_ON    = 2'b01,
    PS_CYCLE = 2'b10
  } pwr_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_BUTTON  = 3'd1,
    CAUSE_WDT     = 3'd2,
    CAUSE_CMD     = 3'd3,
    CAUSE_RETAIN  = 3'd4,
    CAUSE_CHIPSET = 3'd5,
    CAUSE_THERMAL = 3'd6,
    CAUSE_WAKE    = 3'd7
  } pwr_cause_e;

  // Source slots in priority order, slot 0 wins.
  localparam int NUM_SRC  = 7;
  localparam int SRC_IDXW = $clog2(NUM_SRC);
  localparam int SLOT_THERMAL = 0;
  localparam int SLOT_WDT     = 1;
  localparam int SLOT_CMD     = 2;
  localparam int SLOT_BUTTON  = 3;
  localparam int SLOT_CHIPSET = 4;
  localparam int SLOT_WAKE    = 5;
  localparam int SLOT_RETAIN  = 6;

  // Permitted actions per slot: bit0 on, bit1 off, bit2 cycle.
  function automatic logic [2:0] allow_mask(input int slot);
    case (slot)
      SLOT_THERMAL: return 3'b010;
      SLOT_WDT:     return 3'b110;
      SLOT_CMD:     return 3'b111;
      SLOT_BUTTON:  return 3'b011;
      SLOT_CHIPSET: return 3'b011;
      SLOT_WAKE:    return 3'b001;
      SLOT_RETAIN:  return 3'b001;
      default:      return 3'b000;
    endcase
  endfunction

  function automatic pwr_cause_e cause_of(input logic [SRC_IDXW-1:0] slot);
    case (slot)
      3'd0:    return CAUSE_THERMAL;
      3'd1:    return CAUSE_WDT;
      3'd2:    return CAUSE_CMD;
      3'd3:    return CAUSE_BUTTON;
      3'd4:    return CAUSE_CHIPSET;
      3'd5:    return CAUSE_WAKE;
      3'd6:    return CAUSE_RETAIN;
      default: return CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pwr_src_filter.sv
`timescale 1ns/1ps
module pwr_src_filter
  import pwr_arb_pkg::*;
#(
  parameter logic [2:0] ALLOW = 3'b111
) (
  input  logic [1:0] act,
  input  logic       st_on,
  input  logic       st_off,
  input  logic       on_block,
  output logic       req_vld,
  output logic [1:0] req_act
);

  // A request survives only if its source may make it and it would change the state.
  always_comb begin
    req_act = act;
    case (act)
      ACT_ON:    req_vld = ALLOW[0] & st_off & ~on_block;
      ACT_OFF:   req_vld = ALLOW[1] & st_on;
      ACT_CYCLE: req_vld = ALLOW[2] & st_on;
      default:   req_vld = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwr_prio_pick.sv
`timescale 1ns/1ps
module pwr_prio_pick #(
  parameter int N    = 7,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]      vld,
  input  logic [N-1:0][1:0] acts,
  output logic              any,
  output logic [IDXW-1:0]   idx,
  output logic [1:0]        act
);

  // Walk from the lowest priority up, so the lowest valid slot wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    act = 2'b00;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i]) begin
        any = 1'b1;
        idx = IDXW'(i);
        act = acts[i];
      end
    end
  end

endmodule

// File: rtl/pwr_cycle_timer.sv
`timescale 1ns/1ps
module pwr_cycle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] ticks,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= ticks;
    end else if (run && !done) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // A load of zero behaves as one tick.
  assign done = (cnt <= CNT_W'(1));

endmodule

// File: rtl/pwr_state_ctl.sv
`timescale 1ns/1ps
module pwr_state_ctl
  import pwr_arb_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant_any,
  input  logic [1:0]      grant_act,
  input  logic [IDXW-1:0] grant_slot,
  input  logic            timer_done,
  input  logic            thermal,
  output logic            timer_load,
  output pwr_state_e      state,
  output logic            pwr_en,
  output pwr_cause_e      cause,
  output logic            change_pulse
);

  assign timer_load = (state == PS_ON) && grant_any && (grant_act == ACT_CYCLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= PS_OFF;
      pwr_en       <= 1'b0;
      cause        <= CAUSE_NONE;
      change_pulse <= 1'b0;
    end else begin
      change_pulse <= 1'b0;
      case (state)
        PS_OFF: begin
          if (grant_any && grant_act == ACT_ON) begin
            state        <= PS_ON;
            pwr_en       <= 1'b1;
            cause        <= cause_of(grant_slot);
            change_pulse <= 1'b1;
          end
        end
        PS_ON: begin
          if (grant_any && grant_act == ACT_OFF) begin
            state        <= PS_OFF;
            pwr_en       <= 1'b0;
            cause        <= cause_of(grant_slot);
            change_pulse <= 1'b1;
          end else if (grant_any && grant_act == ACT_CYCLE) begin
            state        <= PS_CYCLE;
            pwr_en       <= 1'b0;
            cause        <= cause_of(grant_slot);
            change_pulse <= 1'b1;
          end
        end
        PS_CYCLE: begin
          if (timer_done) begin
            if (thermal) begin
              state <= PS_OFF;
              cause <= CAUSE_THERMAL;
            end else begin
              state        <= PS_ON;
              pwr_en       <= 1'b1;
              change_pulse <= 1'b1;
            end
          end
        end
        default: begin
          state  <= PS_OFF;
          pwr_en <= 1'b0;
        end
      endcase
    end
  end

  // R9: while the window is still open, power stays off.
  assert_cycle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == PS_CYCLE && !timer_done) |=> (state == PS_CYCLE && !pwr_en));

  // R9: a window that ends without a thermal trip restores power.
  assert_cycle_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (state == PS_CYCLE && timer_done && !thermal) |=> (state == PS_ON && pwr_en));

endmodule

// File: rtl/pwr_ctrl_arbiter.sv
`timescale 1ns/1ps
module pwr_ctrl_arbiter
  import pwr_arb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_press,
  input  logic [1:0]       wdt_action,
  input  logic [1:0]       cmd_action,
  input  logic             ac_return,
  input  logic             restore_en,
  input  logic             chipset_sleep,
  input  logic             thermal_trip,
  input  logic             wake_lan,
  input  logic [CNT_W-1:0] off_ticks,
  output logic             pwr_en,
  output logic [1:0]       pwr_state,
  output logic [2:0]       last_cause,
  output logic             change_pulse
);

  pwr_state_e           state;
  pwr_cause_e           cause;
  logic                 st_on, st_off;
  logic                 sleep_q, sleep_rise, sleep_fall;
  logic [NUM_SRC-1:0][1:0] src_act;
  logic [NUM_SRC-1:0][1:0] flt_act;
  logic [NUM_SRC-1:0]   flt_vld;
  logic                 g_any;
  logic [SRC_IDXW-1:0]  g_slot;
  logic [1:0]           g_act;
  logic                 t_load, t_done;

  assign st_on  = (state == PS_ON);
  assign st_off = (state == PS_OFF);

  // Edge detector for the chipset sleep level.
  always_ff @(posedge clk) begin
    if (rst) sleep_q <= 1'b1;
    else     sleep_q <= chipset_sleep;
  end
  assign sleep_rise = chipset_sleep & ~sleep_q;
  assign sleep_fall = ~chipset_sleep & sleep_q;

  // Turn each initiator into an action code.
  always_comb begin
    src_act[SLOT_THERMAL] = thermal_trip ? ACT_OFF : ACT_NONE;
    src_act[SLOT_WDT]     = wdt_action;
    src_act[SLOT_CMD]     = cmd_action;
    src_act[SLOT_BUTTON]  = btn_press ? (st_on ? ACT_OFF : ACT_ON) : ACT_NONE;
    src_act[SLOT_CHIPSET] = sleep_rise ? ACT_OFF : (sleep_fall ? ACT_ON : ACT_NONE);
    src_act[SLOT_WAKE]    = wake_lan ? ACT_ON : ACT_NONE;
    src_act[SLOT_RETAIN]  = (ac_return && restore_en) ? ACT_ON : ACT_NONE;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pwr_src_filter #(.ALLOW(allow_mask(s))) u_flt (
      .act      (src_act[s]),
      .st_on    (st_on),
      .st_off   (st_off),
      .on_block (thermal_trip),
      .req_vld  (flt_vld[s]),
      .req_act  (flt_act[s])
    );
  end

  pwr_prio_pick #(.N(NUM_SRC), .IDXW(SRC_IDXW)) u_pick (
    .vld  (flt_vld),
    .acts (flt_act),
    .any  (g_any),
    .idx  (g_slot),
    .act  (g_act)
  );

  pwr_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (t_load),
    .ticks (off_ticks),
    .run   (state == PS_CYCLE),
    .done  (t_done)
  );

  pwr_state_ctl #(.IDXW(SRC_IDXW)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .grant_any    (g_any),
    .grant_act    (g_act),
    .grant_slot   (g_slot),
    .timer_done   (t_done),
    .thermal      (thermal_trip),
    .timer_load   (t_load),
    .state        (state),
    .pwr_en       (pwr_en),
    .cause        (cause),
    .change_pulse (change_pulse)
  );

  assign pwr_state  = state;
  assign last_cause = cause;

  // R7: a thermal trip leaves power off after the next edge.
  assert_thermal_off_R7: assert property (@(posedge clk) disable iff (rst)
    thermal_trip |=> !pwr_en);

  // R12: the pulse marks exactly the clocks where the enable changed.
  assert_pulse_match_R12: assert property (@(posedge clk) disable iff (rst)
    change_pulse == (pwr_en != $past(pwr_en)));

  // R3: a power-on from state off is never credited to the watchdog or thermal trip.
  assert_no_wdt_on_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_en) && $past(state) == PS_OFF) |->
      (cause != CAUSE_WDT && cause != CAUSE_THERMAL));

  // R5: a retention power-on needs AC return with the policy enabled.
  assert_retain_gate_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_en) && cause == CAUSE_RETAIN) |-> $past(ac_return && restore_en));

  // R8: wake-on-LAN and retention never turn power off.
  assert_on_only_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> (cause != CAUSE_WAKE && cause != CAUSE_RETAIN));

endmodule

// File: tb/pwr_ctrl_arbiter_bench.sv
`timescale 1ns/1ps
module pwr_ctrl_arbiter_bench;

  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             btn_press, ac_return, restore_en, chipset_sleep, thermal_trip, wake_lan;
  logic [1:0]       wdt_action, cmd_action;
  logic [CNT_W-1:0] off_ticks;
  logic             pwr_en, change_pulse;
  logic [1:0]       pwr_state;
  logic [2:0]       last_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  pwr_ctrl_arbiter #(.CNT_W(CNT_W)) u_pwr_ctrl_arbiter (
    .clk(clk), .rst(rst), .btn_press(btn_press), .wdt_action(wdt_action),
    .cmd_action(cmd_action), .ac_return(ac_return), .restore_en(restore_en),
    .chipset_sleep(chipset_sleep), .thermal_trip(thermal_trip), .wake_lan(wake_lan),
    .off_ticks(off_ticks), .pwr_en(pwr_en), .pwr_state(pwr_state),
    .last_cause(last_cause), .change_pulse(change_pulse)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int en, input int st, input int cs, input int pl);
    chk(req, "pwr_en", int'(pwr_en), en);
    chk(req, "pwr_state", int'(pwr_state), st);
    chk(req, "last_cause", int'(last_cause), cs);
    chk(req, "change_pulse", int'(change_pulse), pl);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] a);
    cmd_action = a; tick(); cmd_action = 2'b00;
  endtask

  task automatic go_on();
    if (pwr_state != 2'b01) cmd(2'b01);
    tick();
  endtask

  task automatic go_off();
    if (pwr_state != 2'b00) cmd(2'b10);
    tick();
  endtask

  task automatic wait_window();
    for (int k = 0; k < 200; k++) begin
      if (pwr_state != 2'b10) break;
      tick();
    end
  endtask

  task automatic t_reset();
    chk_out("R1", 0, 0, 0, 0);
    tick();
    chk_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_button();
    btn_press = 1'b1; tick(); btn_press = 1'b0;
    chk_out("R2", 1, 1, 1, 1);
    tick();
    chk("R12", "pulse drops", int'(change_pulse), 0);
    btn_press = 1'b1; tick(); btn_press = 1'b0;
    chk_out("R2", 0, 0, 1, 1);
    tick();
  endtask

  task automatic t_command();
    cmd(2'b11);                       // cycle while off is dropped
    chk_out("R9", 0, 0, 1, 0);
    cmd(2'b01);
    chk_out("R4", 1, 1, 3, 1);
    cmd(2'b10);
    chk_out("R4", 0, 0, 3, 1);
    tick();
  endtask

  task automatic t_watchdog();
    wdt_action = 2'b01; tick(); wdt_action = 2'b00;
    chk_out("R3", 0, 0, 3, 0);
    go_on();
    wdt_action = 2'b10; tick(); wdt_action = 2'b00;
    chk_out("R3", 0, 0, 2, 1);
    go_on();
    wdt_action = 2'b11; tick(); wdt_action = 2'b00;
    chk_out("R3", 0, 2, 2, 1);
    wait_window();
    chk_out("R11", 1, 1, 2, 1);
    go_off();
  endtask

  task automatic t_wake();
    wake_lan = 1'b1; tick(); wake_lan = 1'b0;
    chk_out("R8", 1, 1, 7, 1);
    tick();
    wake_lan = 1'b1; tick(); wake_lan = 1'b0;
    chk_out("R8", 1, 1, 7, 0);
    go_off();
  endtask

  task automatic t_retain();
    restore_en = 1'b0; ac_return = 1'b1; tick(); ac_return = 1'b0;
    chk_out("R5", 0, 0, 3, 0);
    restore_en = 1'b1; ac_return = 1'b1; tick(); ac_return = 1'b0;
    chk_out("R5", 1, 1, 4, 1);
    tick();
    ac_return = 1'b1; tick(); ac_return = 1'b0;
    chk_out("R5", 1, 1, 4, 0);
    restore_en = 1'b0;
    go_off();
  endtask

  task automatic t_chipset();
    chipset_sleep = 1'b0; tick();
    chk_out("R6", 1, 1, 5, 1);
    cmd(2'b10);
    chk_out("R6", 0, 0, 3, 1);
    repeat (3) tick();
    chk("R6", "steady low level", int'(pwr_en), 0);
    chipset_sleep = 1'b1; tick();      // rise while off: nothing
    chk_out("R6", 0, 0, 3, 0);
    chipset_sleep = 1'b0; tick();
    chk_out("R6", 1, 1, 5, 1);
    chipset_sleep = 1'b1; tick();
    chk_out("R6", 0, 0, 5, 1);
    tick();
  endtask

  task automatic t_thermal();
    go_on();
    thermal_trip = 1'b1; tick();
    chk_out("R7", 0, 0, 6, 1);
    btn_press = 1'b1; tick(); btn_press = 1'b0;
    chk_out("R7", 0, 0, 6, 0);
    cmd_action = 2'b01; wake_lan = 1'b1; tick(); cmd_action = 2'b00; wake_lan = 1'b0;
    chk_out("R7", 0, 0, 6, 0);
    thermal_trip = 1'b0; tick();
    wake_lan = 1'b1; tick(); wake_lan = 1'b0;
    chk_out("R7", 1, 1, 7, 1);
    go_off();
  endtask

  task automatic t_priority();
    btn_press = 1'b1; wake_lan = 1'b1; ac_return = 1'b1; restore_en = 1'b1;
    tick();
    btn_press = 1'b0; wake_lan = 1'b0; ac_return = 1'b0; restore_en = 1'b0;
    chk_out("R10", 1, 1, 1, 1);
    tick();
    wdt_action = 2'b11; cmd_action = 2'b10; tick(); wdt_action = 2'b00; cmd_action = 2'b00;
    chk_out("R10", 0, 2, 2, 1);
    wait_window();
    tick();
    cmd_action = 2'b10; btn_press = 1'b1; tick(); cmd_action = 2'b00; btn_press = 1'b0;
    chk_out("R10", 0, 0, 3, 1);
    go_on();
    thermal_trip = 1'b1; wdt_action = 2'b10; tick(); thermal_trip = 1'b0; wdt_action = 2'b00;
    chk_out("R10", 0, 0, 6, 1);
    tick();
  endtask

  task automatic t_cycle(input int n);
    int eff;
    eff = (n == 0) ? 1 : n;
    go_on();
    off_ticks = CNT_W'(n); cmd_action = 2'b11; tick();
    cmd_action = 2'b00; off_ticks = CNT_W'(1);   // later changes must not matter
    chk_out("R9", 0, 2, 3, 1);
    for (int j = 2; j <= eff; j++) begin
      btn_press = 1'b1; wake_lan = 1'b1; tick(); btn_press = 1'b0; wake_lan = 1'b0;
      chk("R9", "window low", int'(pwr_en), 0);
      chk("R13", "cycling state", int'(pwr_state), 2);
    end
    tick();
    chk_out("R9", 1, 1, 3, 1);
    tick();
    chk_out("R9", 1, 1, 3, 0);
    off_ticks = CNT_W'(3);
    go_off();
  endtask

  task automatic t_cycle_thermal();
    go_on();
    off_ticks = CNT_W'(4); cmd(2'b11);
    thermal_trip = 1'b1;
    repeat (5) tick();
    chk_out("R9", 0, 0, 6, 0);
    thermal_trip = 1'b0; tick();
    off_ticks = CNT_W'(3);
  endtask

  initial begin
    rst = 1'b1; btn_press = 1'b0; wdt_action = 2'b00; cmd_action = 2'b00;
    ac_return = 1'b0; restore_en = 1'b0; chipset_sleep = 1'b1; thermal_trip = 1'b0;
    wake_lan = 1'b0; off_ticks = CNT_W'(3);
    repeat (3) tick();
    chk_out("R1", 0, 0, 0, 0);
    rst = 1'b0;
    t_reset();
    t_button();
    t_command();
    t_watchdog();
    t_wake();
    t_retain();
    t_chipset();
    t_thermal();
    t_priority();
    t_cycle(5);
    t_cycle(0);
    t_cycle(1);
    t_cycle(63);
    t_cycle_thermal();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule